// File: doc/BRIEF.md
# Sampled External Interrupt Detector

This block turns one active-low external interrupt pin into a pending-request flag for an interrupt controller. The pin first passes through a two-stage synchronizer. After that it is looked at only once per machine cycle, on a one-clock tick that a divider outside the block raises every 12 clocks. The value taken at each tick is held and driven out as the sampled pin level.

A mode input selects how the flag behaves:

- **Edge mode.** A request is latched when one tick's sample is high and the next tick's sample is low. The latched request stays set until the controller acknowledges that it is vectoring to the handler.
- **Level mode.** The flag simply mirrors the sampled pin being low, and acknowledges do nothing.

The flag comes from a three-state machine:

- **ST_IDLE**: no request.
- **ST_EDGE_HELD**: an edge request is latched.
- **ST_LEVEL_ACTIVE**: a low level is currently sampled in level mode.

Its transitions are:

- **T_FALL**: any state to ST_EDGE_HELD, on an edge event in edge mode.
- **T_ACK**: ST_EDGE_HELD to ST_IDLE, on an acknowledge with no coincident edge event.
- **T_LVL_ON**: to ST_LEVEL_ACTIVE, when level mode sees a low sample.
- **T_LVL_OFF**: to ST_IDLE, when level mode sees a high sample.
- **T_MODE_EDGE**: ST_LEVEL_ACTIVE to ST_IDLE, when edge mode is selected and no edge event occurs.

Top module: `ext_irq_detect`

## Requirements
- R1: While reset is held and after its release, `pending` is 0 and `pin_sampled` is 1, until the pin is sampled low.
- R2: `pin_sampled` changes only on the clock edge at which `mc_tick` is 1.
- R3: After a tick edge, `pin_sampled` equals the value `pin_n` had two clock edges before that tick edge (two-stage synchronizer).
- R4: In edge mode (`edge_mode`=1), an edge event occurs at a tick edge where the previously held sample is 1 and the new sample is 0. On the following cycle `pending` is 1.
- R5: In edge mode, `pending` never rises except on the cycle after an edge event.
- R6: In edge mode, `ack`=1 without a coincident edge event makes `pending` 0 on the next cycle. Without an ack, a latched request stays set.
- R7: When an edge event and `ack` occur on the same edge, `pending` is 1 afterwards.
- R8: In level mode (`edge_mode`=0), `pending` equals the inverse of `pin_sampled` one cycle after the mode was sampled as 0.
- R9: In level mode, `ack` has no effect on `pending`.
- R10: In edge mode, a pin held low produces a single request. After it is acknowledged, `pending` stays 0 until the pin is sampled high and then low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_tick | input | 1 | One-clock machine-cycle sampling tick |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| edge_mode | input | 1 | 1 = falling-edge mode, 0 = low-level mode |
| ack | input | 1 | Controller acknowledge of vectoring |
| pending | output | 1 | Interrupt request flag |
| pin_sampled | output | 1 | Pin value held from the last tick |

## Verification
The bench sweeps every 8-cycle pin pattern in both modes, with the acknowledge placed at varying offsets that include the tick cycle itself. This exposes four kinds of fault:

- **Sampling on every clock.** Glitches shorter than a machine cycle would then latch requests.
- **Wrong synchronizer depth.** The sample would appear one clock early or late.
- **Letting the acknowledge win over a coincident edge.** A real request would be dropped.
- **Honouring the acknowledge in level mode.** Would blank a pin that is still held low.

A directed run holds the pin low after an acknowledge. This catches a detector that re-fires on the level instead of on a high-to-low pair of samples.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE         = 2'd0,
        ST_EDGE_HELD    = 2'd1,
        ST_LEVEL_ACTIVE = 2'd2
    } irq_state_e;

    localparam int unsigned SYNC_DEPTH_DEFAULT = 2;

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    localparam int unsigned TOP = STAGES - 1;

    logic [TOP:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RESET_VAL;
                else        chain <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RESET_VAL}};
                else        chain <= {chain[TOP-1:0], d_async};
            end
        end
    endgenerate

    assign d_sync = chain[TOP];
endmodule

// File: rtl/irq_mc_sampler.sv
module irq_mc_sampler #(
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic d_sync,
    output logic held,
    output logic fall_evt,
    output logic next_low
);
    always_ff @(posedge clk) begin
        if (!rst_n)    held <= IDLE_VAL;
        else if (tick) held <= d_sync;
    end

    // high in the held sample, low in the one being taken now
    assign fall_evt = tick & held & ~d_sync;
    // level the held sample will show after this edge, inverted
    assign next_low = tick ? ~d_sync : ~held;

    // R2: held sample moves only on a tick edge
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(held));
endmodule

// File: rtl/irq_flag_fsm.sv
module irq_flag_fsm
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_mode,
    input  logic ack,
    input  logic fall_evt,
    input  logic next_low,
    input  logic sampled,
    output logic pending
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!edge_mode) begin
            // T_LVL_ON / T_LVL_OFF, ack ignored
            state_d = next_low ? ST_LEVEL_ACTIVE : ST_IDLE;
        end else if (fall_evt) begin
            // T_FALL: edge beats a coincident ack
            state_d = ST_EDGE_HELD;
        end else begin
            unique case (state_q)
                ST_IDLE:         state_d = ST_IDLE;
                ST_EDGE_HELD:    state_d = ack ? ST_IDLE : ST_EDGE_HELD;  // T_ACK
                ST_LEVEL_ACTIVE: state_d = ST_IDLE;                       // T_MODE_EDGE
                default:         state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_EDGE_HELD, ST_LEVEL_ACTIVE: pending = 1'b1;
            default:                       pending = 1'b0;
        endcase
    end

    // R4 / R7: an edge event always yields a pending flag
    a_r4_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && fall_evt) |=> pending);
    // R5: in edge mode the flag rises only after an edge event
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(edge_mode) && $rose(pending)) |-> $past(fall_evt));
    // R6: acknowledge clears in edge mode
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && ack && !fall_evt) |=> !pending);
    // R8 / R9: level mode mirrors the sample regardless of ack
    a_r8_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!edge_mode) |-> (pending == !sampled));
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import ext_irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_tick,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic ack,
    output logic pending,
    output logic pin_sampled
);
    localparam logic PIN_IDLE = 1'b1;

    logic pin_sync, fall_evt, next_low, held;

    irq_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(PIN_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pin_n), .d_sync(pin_sync));

    irq_mc_sampler #(.IDLE_VAL(PIN_IDLE)) u_samp (
        .clk(clk), .rst_n(rst_n), .tick(mc_tick), .d_sync(pin_sync),
        .held(held), .fall_evt(fall_evt), .next_low(next_low));

    irq_flag_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode), .ack(ack),
        .fall_evt(fall_evt), .next_low(next_low), .sampled(held),
        .pending(pending));

    assign pin_sampled = held;

    // R1: reset leaves no request
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!pending && pin_sampled));
endmodule

// File: tb/tb_ext_irq_detect.sv
module tb_ext_irq_detect;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mc_tick = 1'b0;
    logic pin_n = 1'b1;
    logic edge_mode = 1'b1;
    logic ack = 1'b0;
    logic pending, pin_sampled;

    int checks = 0;
    int errors = 0;
    int tcnt = 0;
    bit done = 1'b0;

    // reference state, built from the requirements
    logic m_s1, m_s2, m_held, m_lat, m_lvl;

    always #10 clk = ~clk;

    ext_irq_detect dut (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .pin_n(pin_n),
        .edge_mode(edge_mode), .ack(ack), .pending(pending),
        .pin_sampled(pin_sampled));

    always @(posedge clk) begin
        logic ev;
        if (!rst_n) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_held <= 1'b1;
            m_lat <= 1'b0; m_lvl <= 1'b0;
        end else begin
            ev = mc_tick && m_held && !m_s2;       // R4 edge event
            m_s1 <= pin_n;                          // R3 two stages
            m_s2 <= m_s1;
            if (mc_tick) m_held <= m_s2;            // R2
            if (edge_mode) begin
                m_lat <= ev || (m_lat && !ack);     // R6, R7
                m_lvl <= 1'b0;
            end else begin
                m_lat <= 1'b0;
                m_lvl <= mc_tick ? !m_s2 : !m_held; // R8, R9
            end
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        check("R3 pin_sampled", pin_sampled, m_held);
        check(edge_mode ? "R4/R5/R6/R7 pending" : "R8/R9 pending",
              pending, m_lat | m_lvl);
        tcnt = (tcnt + 1) % 12;
        mc_tick = (tcnt == 11);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic to_offset(input int k);
        do cyc(); while (tcnt != k);
    endtask

    initial begin
        run(4);
        check("R1 reset pending", pending, 1'b0);
        check("R1 reset sampled", pin_sampled, 1'b1);
        @(negedge clk); rst_n = 1'b1;
        run(30);
        check("R1 idle pending", pending, 1'b0);

        // sweep: both modes, all 8-cycle pin patterns, ack at moving offsets
        for (int mode = 0; mode < 2; mode++) begin
            edge_mode = mode[0];
            for (int pat = 0; pat < 256; pat++) begin
                for (int mc = 0; mc < 8; mc++) begin
                    for (int off = 0; off < 12; off++) begin
                        if (off == 3) pin_n = pat[mc];
                        ack = (off == (pat % 12)) && (mc == ((pat >> 4) % 8));
                        cyc();
                    end
                end
                ack = 1'b0;
            end
        end

        // R9: level mode, pin low, ack has no effect
        edge_mode = 1'b0; pin_n = 1'b0;
        run(36);
        ack = 1'b1; run(24); ack = 1'b0;
        check("R9 ack ignored", pending, 1'b1);

        // R10: edge mode, held low, single request
        edge_mode = 1'b1; pin_n = 1'b1;
        run(36);
        pin_n = 1'b0;
        run(36);
        check("R10 request", pending, 1'b1);
        ack = 1'b1; cyc(); ack = 1'b0;
        run(60);
        check("R10 no refire", pending, 1'b0);

        // R7: ack held across the tick that carries an edge event
        pin_n = 1'b1;
        run(36);
        to_offset(0);
        pin_n = 1'b0; ack = 1'b1;
        to_offset(0);
        ack = 1'b0;
        check("R7 edge beats ack", pending, 1'b1);
        run(12);

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule